// File: doc/BRIEF.md
# Windowed Histogram Cross-Correlator

This block compares the luminance histograms of two consecutive video frames. Each histogram has 64 bins of 16 bits. An upstream stage writes them into one of two pages of on-chip RAM, as 32-bit words that each hold two bins. When the upstream stage marks a frame complete, the block swaps the pages. The page just written becomes the current histogram and the other page holds the previous one. New writes then go to the other page.

For the correlation, each bin of each histogram is replaced by a three-bin windowed sum: the bin plus its left and right neighbours. A neighbour that falls outside bins 0..63 counts as zero. Both smoothed histograms are streamed through two multiply lanes at the same time. The block accumulates three sums:
- the cross sum of products;
- the sum of squares of the current histogram;
- the sum of squares of the previous histogram.

A later normalisation stage uses these sums. One pass reads 32 word pairs and completes a fixed 35 cycles after it starts.

Top module: `hcc_xcorr`

## Requirements
- R1: After reset `fill_page_o`, `busy_o` and `done_o` are 0 and all three result outputs are 0.
- R2: Word address a of a page holds bin 2a in bits [15:0] and bin 2a+1 in bits [31:16]. A write with `wr_en_i` high while idle stores `wr_data_i` at `wr_addr_i` of the page named by `fill_page_o`.
- R3: Each bin is smoothed as s[i] = h[i-1] + h[i] + h[i+1], with h[-1] = h[64] = 0.
- R4: `corr_o` equals the sum over all 64 bins of s_cur[i]*s_prev[i]. The current page is the one filled before the swap.
- R5: `energy_cur_o` is the sum of s_cur[i]^2 and `energy_prev_o` is the sum of s_prev[i]^2, both over 64 bins.
- R6: A `frame_done_i` sampled while idle toggles `fill_page_o` and raises `busy_o` at the same edge.
- R7: `done_o` is high for exactly one cycle, 35 clock edges after the edge that sampled the starting `frame_done_i`. `busy_o` falls at that same edge.
- R8: While idle, the result outputs hold their values until the next accepted `frame_done_i`.
- R9: While `busy_o` is high, writes are dropped and `frame_done_i` is ignored: the page select does not change and no second pass starts.
- R10: Bins of 16'hFFFF in both pages give exact results, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Histogram word write strobe |
| wr_addr_i | input | 5 | Word address within the fill page |
| wr_data_i | input | 32 | Two 16-bit bins, even bin in the low half |
| frame_done_i | input | 1 | Frame complete: swap pages and start a pass |
| fill_page_o | output | 1 | Page currently receiving writes |
| busy_o | output | 1 | Correlation pass in progress |
| done_o | output | 1 | One-cycle pulse when the results are final |
| corr_o | output | 64 | Cross sum of products of the smoothed histograms |
| energy_cur_o | output | 64 | Sum of squares, current smoothed histogram |
| energy_prev_o | output | 64 | Sum of squares, previous smoothed histogram |

## Verification
Some faults in the window registers show up at the very next `done_o` as wrong sums:
- an uncleared carry register;
- an edge neighbour that is not zeroed;
- a swapped lane.

Single-bin spikes at bins 0 and 63 make these faults visible because they change the two energies while the cross sum stays zero. A wrong page select, or a write that is not dropped, shows up one frame later, when the stale page is correlated. A wrong pipeline depth moves `done_o` away from the 35-edge mark on the first pass.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  parameter int BIN_W      = 16;
  parameter int NBINS      = 64;
  parameter int WORD_W     = 32;
  parameter int RES_W      = 64;
  localparam int LANES     = WORD_W / BIN_W;
  localparam int DEPTH     = NBINS / LANES;
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = AW + 1;
  localparam int SUM_W     = BIN_W + 2;
  localparam int PROD_W    = 2 * SUM_W;
  localparam int ACC_W     = PROD_W + $clog2(NBINS);
  localparam int LATENCY   = DEPTH + 3;
endpackage

// File: rtl/hcc_page_ram.sv
module hcc_page_ram
  import hcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/hcc_window3.sv
module hcc_window3
  import hcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [SUM_W-1:0]  s_even_o,
  output logic [SUM_W-1:0]  s_odd_o
);
  logic [BIN_W-1:0] p0_q, p1_q, q1_q, n0, n1;

  // flush step feeds the zero neighbour past bin 63
  assign n0 = flush_i ? '0 : word_i[BIN_W-1:0];
  assign n1 = flush_i ? '0 : word_i[2*BIN_W-1:BIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q <= '0; p1_q <= '0; q1_q <= '0;
      s_even_o <= '0; s_odd_o <= '0;
    end else if (clr_i) begin
      p0_q <= '0; p1_q <= '0; q1_q <= '0;
    end else if (en_i) begin
      s_even_o <= SUM_W'(q1_q) + SUM_W'(p0_q) + SUM_W'(p1_q);
      s_odd_o  <= SUM_W'(p0_q) + SUM_W'(p1_q) + SUM_W'(n0);
      q1_q <= p1_q;
      p0_q <= n0;
      p1_q <= n1;
    end
  end
endmodule

// File: rtl/hcc_mac.sv
module hcc_mac
  import hcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SUM_W-1:0] a_i [LANES],
  input  logic [SUM_W-1:0] b_i [LANES],
  output logic [ACC_W-1:0] ab_o,
  output logic [ACC_W-1:0] aa_o,
  output logic [ACC_W-1:0] bb_o
);
  logic [PROD_W-1:0] p_ab [LANES];
  logic [PROD_W-1:0] p_aa [LANES];
  logic [PROD_W-1:0] p_bb [LANES];
  logic [ACC_W-1:0]  s_ab, s_aa, s_bb;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign p_ab[l] = PROD_W'(a_i[l]) * PROD_W'(b_i[l]);
    assign p_aa[l] = PROD_W'(a_i[l]) * PROD_W'(a_i[l]);
    assign p_bb[l] = PROD_W'(b_i[l]) * PROD_W'(b_i[l]);
  end

  always_comb begin
    s_ab = ab_o; s_aa = aa_o; s_bb = bb_o;
    for (int l = 0; l < LANES; l++) begin
      s_ab = s_ab + ACC_W'(p_ab[l]);
      s_aa = s_aa + ACC_W'(p_aa[l]);
      s_bb = s_bb + ACC_W'(p_bb[l]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_o <= '0; aa_o <= '0; bb_o <= '0;
    end else if (clr_i) begin
      ab_o <= '0; aa_o <= '0; bb_o <= '0;
    end else if (en_i) begin
      ab_o <= s_ab; aa_o <= s_aa; bb_o <= s_bb;
    end
  end
endmodule

// File: rtl/hcc_xcorr.sv
module hcc_xcorr
  import hcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              frame_done_i,
  output logic              fill_page_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  corr_o,
  output logic [RES_W-1:0]  energy_cur_o,
  output logic [RES_W-1:0]  energy_prev_o
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic          fill_q, cur_q, busy_q, run_q, done_q, kv_q, sv_q, slast_q;
  logic [CW-1:0] cnt_q, k_q;
  logic          start, flush;
  logic [WORD_W-1:0] rd_word [2];
  logic [WORD_W-1:0] win_word [2];
  logic [SUM_W-1:0]  s_even [2];
  logic [SUM_W-1:0]  s_odd [2];
  logic [SUM_W-1:0]  lane_cur [LANES];
  logic [SUM_W-1:0]  lane_prev [LANES];
  logic [ACC_W-1:0]  acc_ab, acc_aa, acc_bb;

  assign start = frame_done_i && !busy_q;
  assign flush = (k_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= 1'b0; cur_q <= 1'b0; busy_q <= 1'b0; run_q <= 1'b0;
      done_q <= 1'b0; kv_q <= 1'b0; sv_q <= 1'b0; slast_q <= 1'b0;
      cnt_q <= '0; k_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        fill_q <= ~fill_q;
        cur_q  <= fill_q;
        busy_q <= 1'b1;
        run_q  <= 1'b1;
        cnt_q  <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) run_q <= 1'b0;
      end
      kv_q    <= run_q;
      k_q     <= cnt_q;
      sv_q    <= kv_q && (k_q != '0);
      slast_q <= kv_q && flush;
      if (sv_q && slast_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_page
    hcc_page_ram u_ram (
      .clk_i   (clk_i),
      .we_i    (wr_en_i && !busy_q && (fill_q == 1'(g))),
      .waddr_i (wr_addr_i),
      .wdata_i (wr_data_i),
      .raddr_i (cnt_q[AW-1:0]),
      .rdata_o (rd_word[g])
    );
  end

  // role 0 = current page, role 1 = previous page
  assign win_word[0] = cur_q ? rd_word[1] : rd_word[0];
  assign win_word[1] = cur_q ? rd_word[0] : rd_word[1];

  for (genvar r = 0; r < 2; r++) begin : g_win
    hcc_window3 u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start),
      .en_i     (kv_q),
      .flush_i  (flush),
      .word_i   (win_word[r]),
      .s_even_o (s_even[r]),
      .s_odd_o  (s_odd[r])
    );
  end

  assign lane_cur[0]  = s_even[0];
  assign lane_cur[1]  = s_odd[0];
  assign lane_prev[0] = s_even[1];
  assign lane_prev[1] = s_odd[1];

  hcc_mac u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .en_i   (sv_q),
    .a_i    (lane_cur),
    .b_i    (lane_prev),
    .ab_o   (acc_ab),
    .aa_o   (acc_aa),
    .bb_o   (acc_bb)
  );

  assign fill_page_o   = fill_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign corr_o        = {{(RES_W-ACC_W){1'b0}}, acc_ab};
  assign energy_cur_o  = {{(RES_W-ACC_W){1'b0}}, acc_aa};
  assign energy_prev_o = {{(RES_W-ACC_W){1'b0}}, acc_bb};
endmodule

// File: rtl/hcc_xcorr_chk.sv
module hcc_xcorr_chk
  import hcc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_done_i,
  input logic             fill_page_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] corr_o,
  input logic [RES_W-1:0] energy_cur_o,
  input logic [RES_W-1:0] energy_prev_o
);
  logic [7:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (!busy_o) age_q <= '0;
    else if (age_q != 8'hFF) age_q <= age_q + 1'b1;
  end

  a_r6_start_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i && !busy_o |=> busy_o && (fill_page_o != $past(fill_page_o)));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> age_q == 8'(LATENCY));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !frame_done_i |=> $stable(corr_o) && $stable(energy_cur_o) && $stable(energy_prev_o));

  a_r9_page_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(fill_page_o));
endmodule

bind hcc_xcorr hcc_xcorr_chk u_chk (.*);

// File: tb/hcc_xcorr_tb.sv
`timescale 1ns/1ps
module hcc_xcorr_tb;
  import hcc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic frame_done = 1'b0;
  logic fill_page, busy, done;
  logic [RES_W-1:0] corr, e_cur, e_prev;

  int checks = 0;
  int fails = 0;
  int model_pg [2][NBINS];
  int model_fill = 0;

  always #2 clk = ~clk;

  hcc_xcorr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .frame_done_i(frame_done), .fill_page_o(fill_page),
    .busy_o(busy), .done_o(done), .corr_o(corr), .energy_cur_o(e_cur),
    .energy_prev_o(e_prev)
  );

  // stimulus table: {kind, seed}
  localparam int NVEC = 8;
  localparam int KIND [NVEC] = '{1, 2, 3, 3, 4, 5, 5, 4};
  localparam int SEED [NVEC] = '{100, 1000, 0, 63, 7, 0, 0, 13};

  function automatic int gen(int kind, int seed, int i);
    case (kind)
      1: return seed & 16'hFFFF;
      2: return (i * seed) & 16'hFFFF;
      3: return (i == seed) ? 16'hFFFF : 0;
      4: return (i * seed * 37 + 11 * i * i + 5) & 16'hFFFF;
      5: return 16'hFFFF;
      default: return 0;
    endcase
  endfunction

  function automatic longint smooth(int pg, int i);
    longint s = model_pg[pg][i];
    if (i > 0) s += model_pg[pg][i-1];
    if (i < NBINS-1) s += model_pg[pg][i+1];
    return s;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_frame(int kind, int seed, int skip_word);
    for (int a = 0; a < DEPTH; a++) begin
      if (a == skip_word) continue;
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = {BIN_W'(gen(kind, seed, 2*a+1)), BIN_W'(gen(kind, seed, 2*a))};
      model_pg[model_fill][2*a]   = gen(kind, seed, 2*a);
      model_pg[model_fill][2*a+1] = gen(kind, seed, 2*a+1);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // starts a pass, optionally pokes it while busy, returns edges to done
  task automatic run_pass(bit poke, output int lat);
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    lat = 1;
    check("R6 busy after start", longint'(busy), 1);
    check("R6 page toggled", longint'(fill_page), longint'(1 - model_fill));
    if (poke) begin
      wr_en = 1'b1; wr_addr = AW'(3); wr_data = 32'h1234_5678;
      frame_done = 1'b1;
      @(negedge clk);
      lat++;
      wr_en = 1'b0; frame_done = 1'b0;
    end
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    model_fill = 1 - model_fill;
  endtask

  task automatic check_results(string tag, bit skip_prev);
    longint xy = 0, xx = 0, yy = 0;
    int cp = 1 - model_fill;
    int pp = model_fill;
    for (int i = 0; i < NBINS; i++) begin
      xy += smooth(cp, i) * smooth(pp, i);
      xx += smooth(cp, i) * smooth(cp, i);
      yy += smooth(pp, i) * smooth(pp, i);
    end
    check({tag, " R4 corr"}, longint'(corr), xy);
    check({tag, " R5 energy_cur"}, longint'(e_cur), xx);
    if (!skip_prev) check({tag, " R5 energy_prev"}, longint'(e_prev), yy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    #1;
    check("R1 fill_page reset", longint'(fill_page), 0);
    check("R1 busy reset", longint'(busy), 0);
    check("R1 done reset", longint'(done), 0);
    check("R1 corr reset", longint'(corr), 0);
    check("R1 energy reset", longint'(e_cur | e_prev), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // prime page 0 with zeros; page 1 is unwritten, so only zero sums are known
    write_frame(0, 0, -1);
    run_pass(1'b0, lat);
    check("R7 latency", lat, LATENCY + 1);
    check("R3 zero cur corr", longint'(corr), 0);
    check("R5 zero cur energy", longint'(e_cur), 0);
    @(negedge clk);
    check("R7 done one cycle", longint'(done), 0);
    check("R7 busy fell", longint'(busy), 0);

    for (int v = 0; v < NVEC; v++) begin
      write_frame(KIND[v], SEED[v], -1);
      run_pass(1'b0, lat);
      check($sformatf("R7 latency vec%0d", v), lat, LATENCY + 1);
      // spikes at bins 0/63 exercise R3 edge zeroing; all-ones checks R10
      check_results($sformatf("vec%0d R3 R2 R10", v), 1'b0);
    end

    // R8: results hold while idle
    begin
      logic [RES_W-1:0] c0;
      c0 = corr;
      repeat (10) @(negedge clk);
      check("R8 corr held idle", longint'(corr), longint'(c0));
    end

    // R9: write and frame_done during a pass are dropped
    write_frame(2, 77, -1);
    run_pass(1'b1, lat);
    check("R9 ignored restart latency", lat, LATENCY + 1);
    check("R9 page unchanged", longint'(fill_page), longint'(model_fill));
    check_results("R9 pass", 1'b0);
    repeat (5) @(negedge clk);
    check("R9 no second pass", longint'(busy), 0);
    write_frame(4, 3, 3);  // word 3 must keep the older frame's bins
    run_pass(1'b0, lat);
    check_results("R9 dropped write", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule